// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page number by reading a two-level page table in memory. Pages are 4 KB and every table entry is one 32-bit word. The upper ten address bits select an entry in the first-level table, which starts at a root base address. That entry names the frame of a second-level table. The next ten address bits select the entry in that table, and that entry names the physical frame.

A client presents a virtual address on the request port while the walker is idle. The walker then issues at most two single-word reads on its memory read port, one at a time, and waits as long as needed for each reply. It finishes with a result that carries either a 20-bit physical page number or a fault flag together with the table level that faulted. If a first-level entry is null, a 1024-page region of the address space is unallocated. In that case the walk stops at once with a fault and the second-level table is never read. The result stays on the port until the client acknowledges it.

Top module: `ptw_walker`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, req_ready is 1 and busy, mem_rd_en and res_valid are all 0.
- R2: A request is taken only on a rising clock edge where req_valid and req_ready are both 1. req_ready is 1 only while no walk is in progress. A req_valid that is held high during a walk has no effect on the reads or on the result.
- R3: On the cycle after a request is taken, mem_rd_en is 1 and mem_rd_addr equals root_base + vaddr[31:22]*4. Both root_base and the virtual address are sampled on the edge that takes the request, so later changes to them have no effect.
- R4: Every table entry uses this format: bit 0 is the valid flag, bits 31:12 hold the frame number, and bits 11:1 are ignored.
- R5: If the first-level entry has bit 0 equal to 0, the walk ends with res_fault=1, res_fault_lvl=0 and res_ppn=0, and it issues no second read (one read in total for the walk).
- R6: If the first-level entry has bit 0 equal to 1, the cycle after its data arrives has mem_rd_en=1 with mem_rd_addr = {entry[31:12], 12'h000} + vaddr[21:12]*4.
- R7: If the second-level entry has bit 0 equal to 1, the result has res_fault=0 and res_ppn = entry[31:12].
- R8: If the second-level entry has bit 0 equal to 0, the result has res_fault=1, res_fault_lvl=1 and res_ppn=0.
- R9: res_valid rises on the cycle after the reply data that ends the walk. It stays high, with res_ppn, res_fault and res_fault_lvl unchanged, until a rising edge where res_ack is 1.
- R10: busy is 1 from the cycle after a request is taken through the edge where res_ack is seen with res_valid. On the next cycle busy is 0 and req_ready is 1.
- R11: Each read is a mem_rd_en pulse that lasts exactly one cycle. The walker waits any number of cycles for mem_rd_valid. A mem_rd_valid that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker is idle and will take a request |
| mem_rd_en | output | 1 | One-cycle read strobe for a table entry |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read reply is present |
| mem_rd_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | Walk result is present |
| res_ppn | output | 20 | Physical page number, 0 on a fault |
| res_fault | output | 1 | Translation failed |
| res_fault_lvl | output | 1 | Table level that faulted: 0 first, 1 second |
| res_ack | input | 1 | Client takes the result |
| busy | output | 1 | A walk is in progress |

## Verification
The bound checker watches several properties on every cycle. It checks that each read strobe lasts only one cycle. It checks that a taken request is followed at once by a read. It checks that the result payload holds steady until it is acknowledged and that an acknowledgement returns the walker to idle. It also checks that a faulting result carries a zero page number. The bench scenarios are needed for the rest: the computed entry addresses at both levels, the early stop after a null first-level entry, and the level reported in each fault. They also cover the corner cases. These are that reply bits 11:1 are ignored, that stray replies and held requests change nothing, that root_base is captured only at acceptance, that reply latencies vary, and that both indices at their maximum of 1023 give the correct addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VADDR_BITS = 32;
  localparam int unsigned PAGE_OFF_BITS = 12;
  localparam int unsigned LEVEL_IDX_BITS = 10;
  localparam int unsigned ENTRY_SHIFT = 2;   // 4-byte entries
  localparam int unsigned FRAME_BITS = VADDR_BITS - PAGE_OFF_BITS;

  typedef enum logic [2:0] {
    WS_IDLE     = 3'd0,
    WS_FETCH_L1 = 3'd1,
    WS_WAIT_L1  = 3'd2,
    WS_FETCH_L2 = 3'd3,
    WS_WAIT_L2  = 3'd4,
    WS_DONE     = 3'd5
  } walk_state_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W    = 32,
  parameter int PG_OFF_W  = 12,
  parameter int TBL_IDX_W = 10,
  parameter int PTE_SHIFT = 2,
  localparam int FRAME_W  = ADDR_W - PG_OFF_W
) (
  input  logic                 second_lvl,
  input  logic [ADDR_W-1:0]    root_base,
  input  logic [FRAME_W-1:0]   table_frame,
  input  logic [TBL_IDX_W-1:0] idx_top,
  input  logic [TBL_IDX_W-1:0] idx_mid,
  output logic [ADDR_W-1:0]    entry_addr
);
  logic [TBL_IDX_W-1:0] idx_sel;
  logic [ADDR_W-1:0]    base_sel;

  always_comb begin
    if (second_lvl) begin
      idx_sel  = idx_mid;
      base_sel = {table_frame, {PG_OFF_W{1'b0}}};
    end else begin
      idx_sel  = idx_top;
      base_sel = root_base;
    end
    entry_addr = base_sel + (ADDR_W'(idx_sel) << PTE_SHIFT);
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rd_valid,
  input  logic        entry_ok,
  input  logic        res_ack,
  output walk_state_t state_q,
  output logic        take_req,
  output logic        load_l1,
  output logic        load_res
);
  walk_state_t state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE:     if (req_valid) state_d = WS_FETCH_L1;
      WS_FETCH_L1: state_d = WS_WAIT_L1;
      WS_WAIT_L1:  if (rd_valid) state_d = entry_ok ? WS_FETCH_L2 : WS_DONE;
      WS_FETCH_L2: state_d = WS_WAIT_L2;
      WS_WAIT_L2:  if (rd_valid) state_d = WS_DONE;
      WS_DONE:     if (res_ack) state_d = WS_IDLE;
      default:     state_d = WS_IDLE;
    endcase
  end

  always_comb begin
    take_req = (state_q == WS_IDLE) && req_valid;
    load_l1  = (state_q == WS_WAIT_L1) && rd_valid && entry_ok;
    load_res = ((state_q == WS_WAIT_L1) && rd_valid && !entry_ok) ||
               ((state_q == WS_WAIT_L2) && rd_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg #(
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PPN_W-1:0] ppn_d,
  input  logic             fault_d,
  input  logic             lvl_d,
  output logic [PPN_W-1:0] ppn_q,
  output logic             fault_q,
  output logic             lvl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q   <= '0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else if (load) begin
      ppn_q   <= ppn_d;
      fault_q <= fault_d;
      lvl_q   <= lvl_d;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = VADDR_BITS,
  parameter int PG_OFF_W  = PAGE_OFF_BITS,
  parameter int TBL_IDX_W = LEVEL_IDX_BITS,
  parameter int PTE_SHIFT = ENTRY_SHIFT,
  localparam int FRAME_W  = ADDR_W - PG_OFF_W,
  localparam int TOP_LSB  = ADDR_W - TBL_IDX_W,
  localparam int MID_LSB  = PG_OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  root_base,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [ADDR_W-1:0]  mem_rd_data,
  output logic               res_valid,
  output logic [FRAME_W-1:0] res_ppn,
  output logic               res_fault,
  output logic               res_fault_lvl,
  input  logic               res_ack,
  output logic               busy
);
  walk_state_t          state_q;
  logic                 take_req, load_l1, load_res;
  logic [ADDR_W-1:0]    root_q;
  logic [TBL_IDX_W-1:0] idx_top_q, idx_mid_q;
  logic [FRAME_W-1:0]   l1_frame_q;
  logic                 entry_ok;
  logic [FRAME_W-1:0]   ppn_d;
  logic                 lvl_d;
  logic [PG_OFF_W+PG_OFF_W-2:0] unused_bits;

  assign entry_ok    = mem_rd_data[0];
  assign unused_bits = {req_vaddr[PG_OFF_W-1:0], mem_rd_data[PG_OFF_W-1:1]};

  ptw_walk_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .rd_valid (mem_rd_valid),
    .entry_ok (entry_ok),
    .res_ack  (res_ack),
    .state_q  (state_q),
    .take_req (take_req),
    .load_l1  (load_l1),
    .load_res (load_res)
  );

  // request capture: root and both indices frozen at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q    <= '0;
      idx_top_q <= '0;
      idx_mid_q <= '0;
    end else if (take_req) begin
      root_q    <= root_base;
      idx_top_q <= req_vaddr[TOP_LSB +: TBL_IDX_W];
      idx_mid_q <= req_vaddr[MID_LSB +: TBL_IDX_W];
    end
  end

  // second-level table frame from a valid first-level entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       l1_frame_q <= '0;
    else if (load_l1) l1_frame_q <= mem_rd_data[ADDR_W-1:PG_OFF_W];
  end

  ptw_entry_addr #(
    .ADDR_W   (ADDR_W),
    .PG_OFF_W (PG_OFF_W),
    .TBL_IDX_W(TBL_IDX_W),
    .PTE_SHIFT(PTE_SHIFT)
  ) u_addr (
    .second_lvl (state_q == WS_FETCH_L2),
    .root_base  (root_q),
    .table_frame(l1_frame_q),
    .idx_top    (idx_top_q),
    .idx_mid    (idx_mid_q),
    .entry_addr (mem_rd_addr)
  );

  assign ppn_d = entry_ok ? mem_rd_data[ADDR_W-1:PG_OFF_W] : '0;
  assign lvl_d = (state_q == WS_WAIT_L2);

  ptw_result_reg #(.PPN_W(FRAME_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_res),
    .ppn_d  (ppn_d),
    .fault_d(!entry_ok),
    .lvl_d  (lvl_d),
    .ppn_q  (res_ppn),
    .fault_q(res_fault),
    .lvl_q  (res_fault_lvl)
  );

  assign req_ready = (state_q == WS_IDLE);
  assign busy      = (state_q != WS_IDLE);
  assign mem_rd_en = (state_q == WS_FETCH_L1) || (state_q == WS_FETCH_L2);
  assign res_valid = (state_q == WS_DONE);
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int FRAME_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_rd_en,
  input logic               res_valid,
  input logic [FRAME_W-1:0] res_ppn,
  input logic               res_fault,
  input logic               res_fault_lvl,
  input logic               res_ack,
  input logic               busy
);
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R3
  accept_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_en && busy));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_ppn) &&
                                 $stable(res_fault) && $stable(res_fault_lvl)));

  // R10
  res_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy && !mem_rd_en));

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> (!busy && req_ready && !res_valid));

  // R5
  fault_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_ppn == '0));
endmodule

bind ptw_walker ptw_walker_chk #(.FRAME_W(FRAME_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_rd_en    (mem_rd_en),
  .res_valid    (res_valid),
  .res_ppn      (res_ppn),
  .res_fault    (res_fault),
  .res_fault_lvl(res_fault_lvl),
  .res_ack      (res_ack),
  .busy         (busy)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        res_valid;
  logic [19:0] res_ppn;
  logic        res_fault;
  logic        res_fault_lvl;
  logic        res_ack = 1'b0;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit run_cmp = 0;

  ptw_walker uut (.*);

  always #2.5 clk = ~clk;

  // sparse table memory, absent words read as 0
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // memory responder with programmable latency, plus stray-reply injection
  bit pend = 0;
  bit spur = 0;
  int cnt = 0;
  int lat_cfg = 0;
  int rd_count = 0;
  logic [31:0] paddr = '0;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = rd_word(paddr);
        pend = 0;
      end else cnt--;
    end else if (spur) begin
      mem_rd_valid = 1'b1;
      mem_rd_data  = 32'hFFFF_FFFF;
    end
    if (rst_n && mem_rd_en) begin
      pend = 1; paddr = mem_rd_addr; cnt = lat_cfg; rd_count++;
    end
  end

  // behavioural reference: phase 0 idle, 1/3 issue, 2/4 await, 5 result
  int          m_phase = 0;
  logic [31:0] m_va = '0, m_root = '0, m_l1 = '0;
  bit          m_fault = 0, m_lvl = 0;
  logic [19:0] m_ppn = '0;
  always @(posedge clk) begin
    if (!rst_n) m_phase = 0;
    else begin
      case (m_phase)
        0: if (req_valid) begin m_va = req_vaddr; m_root = root_base; m_phase = 1; end
        1: m_phase = 2;
        2: if (mem_rd_valid) begin
             if (mem_rd_data[0]) begin m_l1 = mem_rd_data; m_phase = 3; end
             else begin m_fault = 1; m_lvl = 0; m_ppn = '0; m_phase = 5; end
           end
        3: m_phase = 4;
        4: if (mem_rd_valid) begin
             m_fault = !mem_rd_data[0];
             m_lvl   = 1;
             m_ppn   = mem_rd_data[0] ? mem_rd_data[31:12] : 20'h0;
             m_phase = 5;
           end
        5: if (res_ack) m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp) begin
      chk(busy == (m_phase != 0), "R10", "busy", 32'(busy), 32'(m_phase != 0));
      chk(req_ready == (m_phase == 0), "R2", "req_ready", 32'(req_ready), 32'(m_phase == 0));
      chk(mem_rd_en == (m_phase == 1 || m_phase == 3), "R11", "mem_rd_en",
          32'(mem_rd_en), 32'(m_phase == 1 || m_phase == 3));
      if (m_phase == 1)
        chk(mem_rd_addr == m_root + {20'h0, m_va[31:22], 2'b00}, "R3", "L1 address",
            mem_rd_addr, m_root + {20'h0, m_va[31:22], 2'b00});
      if (m_phase == 3)
        chk(mem_rd_addr == {m_l1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00}, "R6",
            "L2 address", mem_rd_addr, {m_l1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00});
      chk(res_valid == (m_phase == 5), "R9", "res_valid", 32'(res_valid), 32'(m_phase == 5));
      if (m_phase == 5) begin
        chk(res_fault == m_fault, "R9", "res_fault", 32'(res_fault), 32'(m_fault));
        if (m_fault)
          chk(res_fault_lvl == m_lvl, m_lvl ? "R8" : "R5", "fault level",
              32'(res_fault_lvl), 32'(m_lvl));
        chk(res_ppn == m_ppn, "R4", "res_ppn", 32'(res_ppn), 32'(m_ppn));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; errors++;
      $display("FAIL R10 watchdog: cycles %0d expected fewer than %0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic walk(input logic [31:0] va, input int lat, input int ackdly,
                      input bit hold_req, input bit spur_done,
                      input bit exp_fault, input bit exp_lvl, input logic [19:0] exp_ppn,
                      input int exp_reads, input string tag);
    logic [31:0] saved;
    lat_cfg = lat;
    rd_count = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    saved = root_base;
    if (hold_req) begin
      req_vaddr = 32'h0000_5000;   // R2: must not start a second walk
      root_base = 32'hDEAD_0000;   // R3: root sampled only at acceptance
    end else req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(res_fault == exp_fault, tag, "fault flag", 32'(res_fault), 32'(exp_fault));
    if (exp_fault)
      chk(res_fault_lvl == exp_lvl, tag, "fault level", 32'(res_fault_lvl), 32'(exp_lvl));
    chk(res_ppn == exp_ppn, tag, "page number", 32'(res_ppn), 32'(exp_ppn));
    if (spur_done) begin
      @(posedge clk); spur = 1;
      @(posedge clk); spur = 0;
      @(negedge clk);
      chk(res_valid && res_ppn == exp_ppn, "R11", "result after stray reply",
          32'(res_ppn), 32'(exp_ppn));
    end
    repeat (ackdly) @(negedge clk);
    res_ack = 1'b1; req_valid = 1'b0; root_base = saved;
    @(negedge clk);
    res_ack = 1'b0;
    chk(rd_count == exp_reads, tag, "reads issued", rd_count, exp_reads);
    chk(req_ready && !busy, "R10", "idle after ack", 32'(req_ready), 32'd1);
  endtask

  initial begin
    mem[32'h0010_0004] = 32'h0020_0001;
    mem[32'h0020_000C] = 32'hABCD_E001;
    mem[32'h0020_0010] = 32'h1234_5000;
    mem[32'h0030_0FFC] = 32'h0040_0FF1;  // R4: junk in bits 11:1
    mem[32'h0040_0FFC] = 32'hFFFF_FFFF;
    mem[32'h0030_0014] = 32'h0050_0000;  // null first-level entry with frame bits

    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !busy && !mem_rd_en && !res_valid, "R1", "outputs in reset",
        {busy, mem_rd_en, res_valid, req_ready}, 32'b0001);
    rst_n = 1'b1;
    run_cmp = 1;
    @(negedge clk);
    chk(req_ready && !busy && !mem_rd_en && !res_valid, "R1", "outputs after release",
        {busy, mem_rd_en, res_valid, req_ready}, 32'b0001);

    // R7: plain translation, immediate replies
    walk(32'h0040_3ABC, 0, 0, 0, 0, 0, 0, 20'hABCDE, 2, "R7");
    // R5: null first-level entry, no second read
    walk(32'h0800_0123, 2, 1, 0, 0, 1, 0, 20'h0, 1, "R5");
    // R8: invalid second-level entry, slow memory, late ack
    walk(32'h0040_4FFF, 3, 4, 0, 0, 1, 1, 20'h0, 2, "R8");

    // R11: stray reply while idle
    @(posedge clk); spur = 1;
    @(posedge clk); spur = 0;
    @(negedge clk);
    chk(req_ready && !res_valid, "R11", "idle after stray reply", 32'(res_valid), 32'd0);

    // R2/R3/R4: max indices, held request, root changes mid-walk
    root_base = 32'h0030_0000;
    walk(32'hFFFF_F123, 1, 2, 1, 0, 0, 0, 20'hFFFFF, 2, "R4");
    // R5: first-level entry with frame bits but valid clear
    walk(32'h0140_0000, 0, 0, 0, 0, 1, 0, 20'h0, 1, "R5");
    // R9: stray reply during result hold, long latency
    root_base = 32'h0010_0000;
    walk(32'h0040_3000, 5, 3, 0, 1, 0, 0, 20'hABCDE, 2, "R9");
    // R6: back-to-back walk right after ack
    walk(32'h0040_4000, 0, 0, 0, 0, 1, 1, 20'h0, 2, "R6");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule